// File: doc/BRIEF.md
# Serial Controller Interrupt and Watermark Register Bank

This block is the event and interrupt section of a FIFO-based serial port controller. It watches the fill levels of the transmit and receive FIFOs and a mode-fault pulse, and records them in a status register. Software reads that register and clears the sticky bits by writing ones back. A mask selects which status bits may raise the single interrupt line. Software changes the mask only through two write-only ports: one sets mask bits and the other clears them.

A transmit watermark register sets the fill level below which the "transmit low" event fires. The register holds only log2(DEPTH) bits. Software can find the FIFO depth by writing all ones and reading the value back, which gives DEPTH-1. The serial shifter and the FIFO storage are outside the block. They appear here only as fill-level inputs and a fault pulse.

Top module: `irq_regbank`

## Requirements
- R1: Byte offsets decode as follows: status 0x04 (read, write-one-to-clear), mask-set port 0x08 (write only), mask-clear port 0x0C (write only), mask 0x10 (read only), watermark 0x28 (read/write). A read from any other offset, including 0x08 and 0x0C, returns zero.
- R2: Status, mask and both mask ports use one 7-bit layout. Bit 1 is mode fault, bit 2 is transmit fill below watermark, bit 3 is transmit FIFO full (fill equals DEPTH), and bit 4 is receive FIFO not empty (fill nonzero). Bits 0, 5 and 6 of the status always read zero.
- R3: A high `mode_fault` sets status bit 1 at the next clock, and the bit then holds. Writing 1 to bit 1 at 0x04 clears it. Writing 0 leaves it set.
- R4: Status bit 2 is set at every clock where the transmit fill is below the watermark value. Once set, it holds until it is cleared by writing 1.
- R5: If a clear write and a set condition reach bits 1 or 2 in the same cycle, the bit stays set.
- R6: Status bits 3 and 4 follow their FIFO conditions with one clock of delay, and writes to them have no effect.
- R7: Writing to 0x08 sets the mask bits where the written data is 1. Writing to 0x0C clears those mask bits. The mask resets to zero.
- R8: Writes to 0x10 leave the mask unchanged.
- R9: The watermark resets to 1 and stores only the low log2(DEPTH) bits of a write, so writing 0xFFFF reads back DEPTH-1.
- R10: `irq` is a register that is high one clock after any bit of status AND mask is high. It is zero during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| mode_fault | input | 1 | Mode-fault event pulse |
| tx_fill | input | $clog2(DEPTH+1) | Transmit FIFO fill level |
| rx_fill | input | $clog2(DEPTH+1) | Receive FIFO fill level |
| irq | output | 1 | Interrupt request |

## Verification
Read data is combinational, so a register change caused by a write or event in cycle N can be read in the cycle after N's clock edge. The level bits 3 and 4 appear one edge after the FIFO level changes. `irq` follows status and mask one further edge later. It therefore rises two edges after a mode-fault pulse and falls one edge after a mask-clear write has taken effect. Inputs change just after the falling edge, and all comparisons are made on the falling edge. The reference model steps once per rising edge, so each expected value is compared in exactly the cycle it is due.

// File: rtl/irq_regbank_pkg.sv
package irq_regbank_pkg;
   localparam int IRQ_W = 7;

   // byte offsets of the register map
   localparam logic [7:0] OFF_STATUS = 8'h04;
   localparam logic [7:0] OFF_SETMSK = 8'h08;
   localparam logic [7:0] OFF_CLRMSK = 8'h0C;
   localparam logic [7:0] OFF_MASK   = 8'h10;
   localparam logic [7:0] OFF_WMARK  = 8'h28;

   // event bit positions (shared by status, mask and both mask ports)
   localparam int B_FAULT  = 1;
   localparam int B_TXLOW  = 2;
   localparam int B_TXFULL = 3;
   localparam int B_RXDATA = 4;

   // bits latched until cleared, and bits that mirror a level
   localparam logic [IRQ_W-1:0] STICKY_BITS = IRQ_W'((1 << B_FAULT) | (1 << B_TXLOW));
   localparam logic [IRQ_W-1:0] LEVEL_BITS  = IRQ_W'((1 << B_TXFULL) | (1 << B_RXDATA));
endpackage

// File: rtl/irq_status_bits.sv
module irq_status_bits #(
   parameter int W = 7,
   parameter logic [W-1:0] STICKY = '0,
   parameter logic [W-1:0] LEVEL  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_vec,
   input  logic [W-1:0] clr_vec,
   output logic [W-1:0] status
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (STICKY[i]) begin : g_sticky
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) status[i] <= 1'b0;
            else        status[i] <= (status[i] & ~clr_vec[i]) | set_vec[i];
         end
      end else if (LEVEL[i]) begin : g_level
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) status[i] <= 1'b0;
            else        status[i] <= set_vec[i];
         end
      end else begin : g_rsvd
         assign status[i] = 1'b0;
      end
   end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_wr,
   input  logic         clr_wr,
   input  logic [W-1:0] bits,
   output logic [W-1:0] mask
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask <= '0;
      else if (set_wr) mask <= mask | bits;
      else if (clr_wr) mask <= mask & ~bits;
   end
endmodule

// File: rtl/irq_wmark_reg.sv
module irq_wmark_reg #(
   parameter int WM_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [WM_W-1:0] wdata,
   output logic [WM_W-1:0] wmark
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  wmark <= WM_W'(1);
      else if (wr) wmark <= wdata;
   end
endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
   import irq_regbank_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   localparam int FILL_W = $clog2(DEPTH + 1),
   localparam int WM_W   = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              mode_fault,
   input  logic [FILL_W-1:0] tx_fill,
   input  logic [FILL_W-1:0] rx_fill,
   output logic              irq
);
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("irq_regbank: DEPTH must be a power of two of at least 4");
   end
   if (ADDR_W < 6 || DATA_W < 16 || WM_W > DATA_W) begin : g_bad_width
      $error("irq_regbank: ADDR_W must be >= 6 and DATA_W >= 16");
   end

   logic hit_status, hit_setm, hit_clrm, hit_mask, hit_wmark;
   assign hit_status = bus_addr == ADDR_W'(OFF_STATUS);
   assign hit_setm   = bus_addr == ADDR_W'(OFF_SETMSK);
   assign hit_clrm   = bus_addr == ADDR_W'(OFF_CLRMSK);
   assign hit_mask   = bus_addr == ADDR_W'(OFF_MASK);
   assign hit_wmark  = bus_addr == ADDR_W'(OFF_WMARK);

   logic [IRQ_W-1:0] status_q, mask_q, ev_set, ev_clr;
   logic [WM_W-1:0]  wmark_q;

   always_comb begin
      ev_set           = '0;
      ev_set[B_FAULT]  = mode_fault;
      ev_set[B_TXLOW]  = tx_fill < FILL_W'(wmark_q);
      ev_set[B_TXFULL] = tx_fill == FILL_W'(DEPTH);
      ev_set[B_RXDATA] = rx_fill != '0;
   end
   assign ev_clr = (bus_wr && hit_status) ? bus_wdata[IRQ_W-1:0] : '0;

   irq_status_bits #(.W(IRQ_W), .STICKY(STICKY_BITS), .LEVEL(LEVEL_BITS)) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (ev_set),
      .clr_vec (ev_clr),
      .status  (status_q)
   );

   irq_mask_reg #(.W(IRQ_W)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_wr (bus_wr && hit_setm),
      .clr_wr (bus_wr && hit_clrm),
      .bits   (bus_wdata[IRQ_W-1:0]),
      .mask   (mask_q)
   );

   irq_wmark_reg #(.WM_W(WM_W)) u_wmark (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (bus_wr && hit_wmark),
      .wdata (bus_wdata[WM_W-1:0]),
      .wmark (wmark_q)
   );

   always_comb begin
      bus_rdata = '0;
      if (hit_status)     bus_rdata = DATA_W'(status_q);
      else if (hit_mask)  bus_rdata = DATA_W'(mask_q);
      else if (hit_wmark) bus_rdata = DATA_W'(wmark_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |(status_q & mask_q);
   end
endmodule

// File: rtl/irq_regbank_chk.sv
module irq_regbank_chk
   import irq_regbank_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   localparam int FILL_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              mode_fault,
   input logic [FILL_W-1:0] tx_fill,
   input logic [IRQ_W-1:0]  status,
   input logic [IRQ_W-1:0]  mask,
   input logic              irq
);
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   logic clr_fault;
   assign clr_fault = bus_wr && bus_addr == ADDR_W'(OFF_STATUS) && bus_wdata[B_FAULT];

   // R3: a set fault bit survives any cycle without a clear of that bit
   a_r3_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && status[B_FAULT] && !clr_fault) |=> status[B_FAULT]);

   // R5: a fault pulse sets the bit, even against a clear in that cycle
   a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      mode_fault |=> status[B_FAULT]);

   // R6: transmit-full bit mirrors the fill level one edge late
   a_r6_full_level: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> status[B_TXFULL] == $past(tx_fill == FILL_W'(DEPTH)));

   // R7: the set port turns on every written bit
   a_r7_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFF_SETMSK)) |=>
      ((mask & $past(bus_wdata[IRQ_W-1:0])) == $past(bus_wdata[IRQ_W-1:0])));

   // R8: writing the mask offset leaves the mask alone
   a_r8_mask_ro: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFF_MASK)) |=> $stable(mask));

   // R10: interrupt is the registered OR of enabled status bits
   a_r10_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> irq == $past(|(status & mask)));

   // R2: reserved status bits never set
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (status & ~(STICKY_BITS | LEVEL_BITS)) == '0);
endmodule

bind irq_regbank irq_regbank_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .mode_fault (mode_fault),
   .tx_fill    (tx_fill),
   .status     (status_q),
   .mask       (mask_q),
   .irq        (irq)
);

// File: tb/irq_regbank_tb.sv
`timescale 1ns/100ps
module irq_regbank_tb;
   localparam int DEPTH  = 16;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 32;
   localparam int FILL_W = $clog2(DEPTH + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic              mode_fault = 1'b0;
   logic [FILL_W-1:0] tx_fill = FILL_W'(8);
   logic [FILL_W-1:0] rx_fill = '0;
   logic              irq;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   irq_regbank #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_fault(mode_fault),
      .tx_fill(tx_fill), .rx_fill(rx_fill), .irq(irq)
   );

   // behavioural reference model, stepped once per rising edge
   int m_fault, m_low, m_full, m_rx, m_mask, m_wm, m_irq;

   function automatic int m_status();
      return (m_fault << 1) | (m_low << 2) | (m_full << 3) | (m_rx << 4);
   endfunction

   function automatic int m_read(int a);
      if (a == 'h04) return m_status();
      if (a == 'h10) return m_mask;
      if (a == 'h28) return m_wm;
      return 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_fault = 0; m_low = 0; m_full = 0; m_rx = 0; m_mask = 0; m_wm = 1; m_irq = 0;
      end else begin
         int a, d, clr, low_now;
         a = int'(bus_addr);
         d = int'(bus_wdata);
         clr = (bus_wr && a == 'h04) ? d : 0;
         low_now = (int'(tx_fill) < m_wm) ? 1 : 0;
         m_irq = ((m_status() & m_mask) != 0) ? 1 : 0;
         m_fault = ((m_fault != 0 && clr[1] == 1'b0) || mode_fault) ? 1 : 0;
         m_low   = ((m_low != 0 && clr[2] == 1'b0) || low_now != 0) ? 1 : 0;
         m_full  = (int'(tx_fill) == DEPTH) ? 1 : 0;
         m_rx    = (rx_fill != 0) ? 1 : 0;
         if (bus_wr && a == 'h08) m_mask = m_mask | (d & 'h7F);
         if (bus_wr && a == 'h0C) m_mask = m_mask & ~(d & 'h7F);
         if (bus_wr && a == 'h28) m_wm = d & (DEPTH - 1);
      end
   end

   task automatic check(string tag, int got, int exp);
      n_vec++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
      end
   endtask

   // per-cycle comparison against the model on the falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int a;
         string tag;
         a = int'(bus_addr);
         tag = (a == 'h04) ? "R3 status" : (a == 'h10) ? "R7 mask" :
               (a == 'h28) ? "R9 watermark" : "R1 unmapped";
         check(tag, int'(bus_rdata), m_read(a));
         check("R10 irq", int'(irq), m_irq);
      end
   end

   task automatic wr(int a, int d);
      @(negedge clk); #0.5;
      bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = DATA_W'(d);
      @(negedge clk); #0.5;
      bus_wr = 1'b0;
   endtask

   task automatic rd(int a, string tag, int exp);
      @(negedge clk); #0.5;
      bus_addr = ADDR_W'(a);
      #0.5;
      check(tag, int'(bus_rdata), exp);
   endtask

   task automatic fault_pulse();
      @(negedge clk); #0.5; mode_fault = 1'b1;
      @(negedge clk); #0.5; mode_fault = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      // reset values, read during reset (R1, R2, R7, R9, R10)
      rd('h04, "R2 reset status", 0);
      rd('h10, "R7 reset mask", 0);
      rd('h28, "R9 reset watermark", 1);
      rd('h08, "R1 setport reads zero", 0);
      check("R10 reset irq", int'(irq), 0);
      @(negedge clk); #0.5; rst_n = 1'b1;

      // R3: sticky fault, write-0 keeps, write-1 clears
      fault_pulse();
      rd('h04, "R3 fault set", 'h02);
      wr('h04, 'h00);
      rd('h04, "R3 write zero keeps", 'h02);
      wr('h04, 'h02);
      rd('h04, "R3 write one clears", 'h00);

      // R5: clear and event in one cycle
      @(negedge clk); #0.5;
      mode_fault = 1'b1; bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h02;
      @(negedge clk); #0.5;
      mode_fault = 1'b0; bus_wr = 1'b0;
      rd('h04, "R5 event beats clear", 'h02);
      wr('h04, 'h02);

      // R6 and R2: level bits
      @(negedge clk); #0.5; tx_fill = FILL_W'(DEPTH); rx_fill = FILL_W'(2);
      rd('h04, "R6 level bits set", 'h18);
      wr('h04, 'h18);
      rd('h04, "R6 clear write ignored", 'h18);
      @(negedge clk); #0.5; tx_fill = FILL_W'(8); rx_fill = '0;
      rd('h04, "R6 level bits drop", 'h00);

      // R9 depth probe and R4 watermark event
      wr('h28, 'hFFFF);
      rd('h28, "R9 depth probe", DEPTH - 1);
      rd('h04, "R4 below watermark", 'h04);
      @(negedge clk); #0.5; tx_fill = FILL_W'(DEPTH - 1);
      wr('h04, 'h04);
      rd('h04, "R4 equal is not below", 'h00);
      wr('h28, 'h13);
      rd('h28, "R9 upper bits dropped", 'h3);

      // R8, R1, R7
      wr('h10, 'h7F);
      rd('h10, "R8 mask write ignored", 'h00);
      rd('h0C, "R1 clrport reads zero", 0);
      wr('h08, 'h12);
      rd('h10, "R7 set port", 'h12);
      wr('h0C, 'h10);
      rd('h10, "R7 clear port", 'h02);

      // R10: irq timing
      fault_pulse();
      check("R10 irq not yet", int'(irq), 0);
      @(negedge clk);
      check("R10 irq raised", int'(irq), 1);
      wr('h0C, 'h02);
      @(negedge clk);
      check("R10 irq dropped", int'(irq), 0);

      // random traffic compared every cycle against the model
      for (int i = 0; i < 3000; i++) begin
         int sel;
         @(negedge clk); #0.5;
         sel = $urandom_range(6);
         case (sel)
            0: bus_addr = 8'h04;
            1: bus_addr = 8'h08;
            2: bus_addr = 8'h0C;
            3: bus_addr = 8'h10;
            4: bus_addr = 8'h28;
            5: bus_addr = 8'h14;
            default: bus_addr = 8'h00;
         endcase
         bus_wr     = ($urandom_range(3) == 0);
         bus_wdata  = DATA_W'($urandom);
         mode_fault = ($urandom_range(7) == 0);
         tx_fill    = FILL_W'($urandom_range(DEPTH));
         rx_fill    = FILL_W'($urandom_range(2));
      end
      @(negedge clk); #0.5;
      bus_wr = 1'b0; mode_fault = 1'b0;
      @(negedge clk); @(negedge clk);
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule